// File: doc/BRIEF.md
# Octant-Compressed Twiddle Generator

This block supplies the complex rotation factors that a radix-2 FFT butterfly needs. It covers every angle of an N-point transform but keeps only the first 45 degrees of the unit circle in a constant table. A twiddle index is split into two parts. The three leading bits name one of eight octants. The lower bits give the position inside that octant. In octants where the angle runs backward, the position is mirrored. The stored cosine and sine pair is then swapped and negated as needed to land in the right octant.

The result is a 36-bit word that holds an 18-bit real part and an 18-bit imaginary part, both in two's complement. It appears one clock after the index is presented. A direction input picks the forward kernel e^{-jθ} or the inverse kernel e^{+jθ}. The table is built at elaboration from a constant function, so it needs no initialisation file. Angles that are whole quarter turns come out exact.

Top module: `twid_mapper`

## Requirements
- R1: `tw_o[35:18]` holds the real part and `tw_o[17:0]` holds the imaginary part, both 18-bit two's complement. Unity is encoded as 131071 (2^17 − 1).
- R2: While `rst_ni` is low, `tw_o` is zero. Otherwise `tw_o` at each rising edge takes the value for the `idx_i` and `inv_i` sampled at that edge, which is a latency of exactly one cycle.
- R3: Index 0 gives real 131071 and imaginary 0 in both directions.
- R4: Indices that are multiples of N/4 give exact values. In the forward direction they are N/4 → (0, −131071), N/2 → (−131071, 0) and 3N/4 → (0, +131071). The inverse direction flips the imaginary sign.
- R5: In octant 0 (idx_i[LOG2N-1:LOG2N-3] = 0), with the forward direction, the real part is round(131071·cos θ) and the imaginary part is −round(131071·sin θ). Here θ = 2π·idx/N and rounding is half away from zero.
- R6: In odd octants, an in-octant offset of zero selects the 45-degree table entry, so the real and imaginary magnitudes are equal. For example, N/8 forward gives (92681, −92681).
- R7: With `inv_i` = 1 the real part is the same as in the forward direction and the imaginary part is negated.
- R8: For every index in all eight octants, the output equals round(131071·cos θ) for the real part. The imaginary part is ∓round(131071·sin θ), with the minus sign for forward and the plus sign for inverse.
- R9: Neither output part ever takes the value −131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | LOG2N | Twiddle index k, angle 2πk/N |
| inv_i | input | 1 | 0 = forward kernel, 1 = inverse kernel |
| tw_o | output | 36 | Registered twiddle, {real, imag} |

## Verification
The hardest cases are the octant boundaries. In a mirrored octant, an offset of zero must reach the extra 45-degree entry past the end of the stored range. In the remaining octants, an offset of zero must land exactly on an axis. An error in the mirror arithmetic or in a swap/negate choice shows up only at these points, or only in one octant. For that reason the stimulus sweeps every index in both directions through a scoreboard. The scoreboard compares each result against a floating-point model evaluated at the full angle. On top of the sweep, the bench makes named probes at the quarter-turn indices, at the 45-degree indices and at index zero.

// File: rtl/twid_pkg.sv
package twid_pkg;
  localparam int TW_W  = 18;
  localparam int CPX_W = 2 * TW_W;
  localparam int UNITY = (1 << (TW_W - 1)) - 1;

  typedef logic signed [TW_W-1:0] tw_t;

  typedef struct packed {
    tw_t re;
    tw_t im;
  } cplx_t;

  // round half away from zero, scaled to unity
  function automatic tw_t quant(input real v);
    real s;
    int  q;
    s = v * UNITY;
    if (s >= 0.0) q = $rtoi(s + 0.5);
    else          q = -$rtoi(-s + 0.5);
    return tw_t'(q);
  endfunction
endpackage

// File: rtl/twid_rom.sv
module twid_rom
  import twid_pkg::*;
#(
  parameter int OFS_W = 7
) (
  input  logic [OFS_W:0] addr_i,
  output tw_t            cos_o,
  output tw_t            sin_o
);
  localparam int  DEPTH = (1 << OFS_W) + 1;
  localparam real PI    = 3.14159265358979323846;

  tw_t cos_tab [DEPTH];
  tw_t sin_tab [DEPTH];

  // entry m covers angle (pi/4)*m/2^OFS_W, m = 0 .. 2^OFS_W inclusive
  for (genvar m = 0; m < DEPTH; m++) begin : g_ent
    localparam real ANG = (PI / 4.0) * m / (1 << OFS_W);
    assign cos_tab[m] = quant($cos(ANG));
    assign sin_tab[m] = quant($sin(ANG));
  end

  assign cos_o = cos_tab[addr_i];
  assign sin_o = sin_tab[addr_i];
endmodule

// File: rtl/twid_octant_map.sv
module twid_octant_map #(
  parameter int LOG2N = 10,
  localparam int OFS_W = LOG2N - 3
) (
  input  logic [LOG2N-1:0] idx_i,
  output logic [OFS_W:0]   addr_o,
  output logic             swap_o,
  output logic             neg_c_o,
  output logic             neg_s_o
);
  localparam logic [OFS_W:0] OCT_SZ = (OFS_W+1)'(1 << OFS_W);

  logic [2:0]       oct;
  logic [OFS_W-1:0] ofs;

  assign oct = idx_i[LOG2N-1 -: 3];
  assign ofs = idx_i[OFS_W-1:0];

  // odd octants run backward: mirror offset, 0 -> 45 degree entry
  always_comb begin
    if (oct[0]) addr_o = OCT_SZ - {1'b0, ofs};
    else        addr_o = {1'b0, ofs};
  end

  // per octant: take sin as cos, negate cos-phi, negate sin-phi
  always_comb begin
    unique case (oct)
      3'd0: {swap_o, neg_c_o, neg_s_o} = 3'b000;
      3'd1: {swap_o, neg_c_o, neg_s_o} = 3'b100;
      3'd2: {swap_o, neg_c_o, neg_s_o} = 3'b110;
      3'd3: {swap_o, neg_c_o, neg_s_o} = 3'b010;
      3'd4: {swap_o, neg_c_o, neg_s_o} = 3'b011;
      3'd5: {swap_o, neg_c_o, neg_s_o} = 3'b111;
      3'd6: {swap_o, neg_c_o, neg_s_o} = 3'b101;
      3'd7: {swap_o, neg_c_o, neg_s_o} = 3'b001;
      default: {swap_o, neg_c_o, neg_s_o} = 3'b000;
    endcase
  end
endmodule

// File: rtl/twid_mapper.sv
module twid_mapper
  import twid_pkg::*;
#(
  parameter int LOG2N = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LOG2N-1:0] idx_i,
  input  logic             inv_i,
  output logic [35:0]      tw_o
);
  localparam int  OFS_W = LOG2N - 3;
  localparam tw_t U_POS = tw_t'(UNITY);
  localparam tw_t U_NEG = -tw_t'(UNITY);
  localparam tw_t T_MIN = {1'b1, {(TW_W-1){1'b0}}};

  logic [OFS_W:0] rom_addr;
  logic           swap, neg_c, neg_s;
  tw_t            rom_c, rom_s;
  tw_t            cphi, sphi, re_d, sgn_s;
  cplx_t          tw_d, tw_q;

  twid_octant_map #(.LOG2N(LOG2N)) u_map (
    .idx_i  (idx_i),
    .addr_o (rom_addr),
    .swap_o (swap),
    .neg_c_o(neg_c),
    .neg_s_o(neg_s)
  );

  twid_rom #(.OFS_W(OFS_W)) u_rom (
    .addr_i(rom_addr),
    .cos_o (rom_c),
    .sin_o (rom_s)
  );

  always_comb begin
    cphi  = swap ? rom_s : rom_c;
    sphi  = swap ? rom_c : rom_s;
    re_d  = neg_c ? -cphi : cphi;
    sgn_s = neg_s ? -sphi : sphi;
    // forward kernel is e^{-j theta}
    tw_d.re = re_d;
    tw_d.im = inv_i ? sgn_s : -sgn_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tw_q <= '0;
    else         tw_q <= tw_d;
  end

  assign tw_o = tw_q;

  // checking only
  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  tw_t re_w, im_w;
  assign re_w = tw_o[35:18];
  assign im_w = tw_o[17:0];

  AST_NO_MIN_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_w != T_MIN) && (im_w != T_MIN)); // R9

  AST_ZERO_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && ($past(idx_i) == '0) |-> (re_w == U_POS) && (im_w == '0)); // R3

  AST_QUARTER_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && ($past(idx_i[LOG2N-3:0]) == '0) |->
      ((re_w == '0) && ((im_w == U_POS) || (im_w == U_NEG))) ||
      ((im_w == '0) && ((re_w == U_POS) || (re_w == U_NEG)))); // R4

  AST_DIAG_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && ($past(idx_i[OFS_W-1:0]) == '0) && $past(idx_i[LOG2N-3]) |->
      (re_w == im_w) || (re_w == -im_w)); // R6
endmodule

// File: tb/twid_mapper_bench.sv
module twid_mapper_bench;
  localparam int  LOG2N = 10;
  localparam int  N     = 1 << LOG2N;
  localparam int  U     = 131071;
  localparam real PI    = 3.14159265358979323846;

  typedef struct {
    logic [35:0] d;
    string       tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LOG2N-1:0] idx = '0;
  logic             inv = 1'b0;
  logic [35:0]      tw;

  int checks = 0;
  int errors = 0;
  logic drv_v = 1'b0;
  logic mon_v = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  twid_mapper #(.LOG2N(LOG2N)) u_twid_mapper (
    .clk_i (clk),
    .rst_ni(rst_n),
    .idx_i (idx),
    .inv_i (inv),
    .tw_o  (tw)
  );

  function automatic int rnd(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic logic [35:0] model(input int k, input logic iv);
    real a;
    int  c, s;
    a = 2.0 * PI * k / N;
    c = rnd(U * $cos(a));
    s = rnd(U * $sin(a));
    return {18'(c), 18'(iv ? s : -s)};
  endfunction

  task automatic drive(input int k, input logic iv, input logic [35:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    idx   = LOG2N'(k);
    inv   = iv;
    drv_v = 1'b1;
    it.d  = e;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  always @(posedge clk) mon_v <= drv_v;

  always @(negedge clk) begin
    if (mon_v && exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if (tw !== it.d) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", it.tag, tw, it.d);
      end
    end
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (tw !== 36'h0) begin
      errors++;
      $display("FAIL R2 reset act=%h exp=0", tw);
    end
    rst_n = 1'b1;

    // R1 packing and R3 unity at index 0
    drive(0, 1'b0, {18'h1FFFF, 18'h00000}, "R1");
    drive(0, 1'b1, {18'd131071, 18'd0}, "R3");
    // R2: back-to-back changes, each result one cycle later
    drive(N/2, 1'b0, {18'(-131071), 18'd0}, "R2");
    drive(1, 1'b0, model(1, 1'b0), "R2");
    // R4 quarter turns
    drive(N/4,   1'b0, {18'd0, 18'(-131071)}, "R4");
    drive(N/4,   1'b1, {18'd0, 18'd131071}, "R4");
    drive(N/2,   1'b1, {18'(-131071), 18'd0}, "R4");
    drive(3*N/4, 1'b0, {18'd0, 18'd131071}, "R4");
    drive(3*N/4, 1'b1, {18'd0, 18'(-131071)}, "R4");
    // R6 45-degree boundaries
    drive(N/8,   1'b0, {18'd92681, 18'(-92681)}, "R6");
    drive(3*N/8, 1'b0, {18'(-92681), 18'(-92681)}, "R6");
    drive(5*N/8, 1'b0, {18'(-92681), 18'd92681}, "R6");
    drive(7*N/8, 1'b1, {18'd92681, 18'(-92681)}, "R6");
    // R5 octant 0 values
    for (int k = 1; k < N/8; k += 9) drive(k, 1'b0, model(k, 1'b0), "R5");
    // R7 inverse against forward in each octant
    for (int o = 0; o < 8; o++) begin
      logic [35:0] f;
      int k;
      k = o * (N/8) + 5;
      f = model(k, 1'b0);
      drive(k, 1'b1, {f[35:18], 18'(-$signed(f[17:0]))}, "R7");
    end
    // R8 full sweep, both directions
    for (int k = 0; k < N; k++) drive(k, 1'b0, model(k, 1'b0), "R8");
    for (int k = 0; k < N; k++) drive(k, 1'b1, model(k, 1'b1), "R8");

    @(negedge clk);
    drv_v = 1'b0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule